// File: doc/BRIEF.md
# Bit-Serial Instruction ROM Bank

This block is one bank of a program memory built from several identical chips that share two single-bit lines. Every word time a sequencer sends an 8-bit address, least significant bit first, on a serial address line. Every bank captures it and looks up its own 256 x 10-bit store. Only the bank whose enable flip-flop is set then sends the 10-bit instruction, least significant bit first, onto the shared instruction line. A disabled bank drives 0, so the outputs of all banks are ORed into one line.

No chip-select exists. Each bank watches the shared instruction line. When a bank-select instruction passes on it, the bank sets or clears its own enable. An init input, like reset, enables bank 0 and disables the others, so that execution starts at address 0 of bank 0. Word timing comes from a sync input. The bit counter starts one clock period after sync falls and then runs freely over a 56-bit word.

Top module: `serial_rom_bank`

## Requirements
- R1: The address bit for position k (k = 0..7, bit 0 first) is sampled at the clock edge that ends bit period k of the word.
- R2: During bit periods 8..17, the enabled bank drives bit j = period - 8 of the stored word at the captured address. The stored word for bank b at address a is {a[2:0], 2'b00, 5'b10000} when a[7:3] = 5'b11110. Otherwise it is (13*a + 101*b + 5) mod 1024, with bit 0 forced to 1 when its low five bits come out as 10000.
- R3: When sync is sampled high at one edge and low at the next edge n, bit period 0 is the clock cycle that starts at edge n+1. The word counter then wraps every 56 bit periods without a further sync. Holding sync high for several cycles does not change this offset.
- R4: The instruction output is 0 while the bank is disabled and outside bit periods 8..17.
- R5: A word on the shared instruction line whose low five bits are 10000 is a bank select, and bits 9:7 give the bank number. At the end of bit period 17, a bank whose number matches becomes enabled and every other bank becomes disabled, starting with the next word. A select naming a bank that does not exist leaves all banks disabled. Other words leave the enable unchanged.
- R6: Reset or one cycle of init makes bank 0 enabled and banks 1 and 2 disabled.
- R7: With three banks sharing the line, exactly the bank chosen by the last select or init supplies each word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low reset |
| initIn | input | 1 | Init: forces bank 0 as the active bank |
| syncIn | input | 1 | Word sync; its falling edge sets word timing |
| addrIn | input | 1 | Serial address, LSB first |
| instrBus | input | 1 | Shared instruction line, observed for bank selects |
| instrOut | output | 1 | This bank's serial instruction contribution |

## Verification
The bench goes after the offset from sync to word start. A counter that started one cycle early or late would shift the address by a bit and return the wrong word at every fetch. The free-running wrap and a long sync pulse check that the timing survives without a fresh sync and does not depend on pulse width. A select that names a missing bank must silence the whole line. A design that only set enables, and never cleared them, would keep the old bank driving there. Init after a switch must bring back bank 0 alone. A bank that missed the clear would OR its bits into bank 0's words.

// File: rtl/srom_pkg.sv
package srom_pkg;
  localparam int ADDR_BITS  = 8;
  localparam int INSTR_BITS = 10;
  localparam logic [INSTR_BITS-1:0] SEL_MASK = 10'b0000011111;
  localparam logic [INSTR_BITS-1:0] SEL_CODE = 10'b0000010000;

  typedef struct packed {
    logic addrShift;
    logic instrLoad;
    logic instrShift;
    logic outWin;
    logic snoopShift;
    logic decode;
  } strobe_t;

  // Content rule shared by all banks; select words sit at 0xF0..0xF7.
  function automatic logic [INSTR_BITS-1:0] romWord(input int bank, input int addr);
    logic [INSTR_BITS-1:0] v;
    logic [7:0] a;
    a = addr[7:0];
    if (a[7:3] == 5'b11110) begin
      v = {a[2:0], 2'b00, 5'b10000};
    end else begin
      v = INSTR_BITS'((13 * addr + 101 * bank + 5) % 1024);
      if (v[4:0] == 5'b10000) v[0] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/srom_ctrl.sv
module srom_ctrl import srom_pkg::*; #(
  parameter int WORD_BITS = 56,
  parameter int ABITS     = 8,
  parameter int IBITS     = 10,
  localparam int CW       = $clog2(WORD_BITS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncIn,
  output strobe_t       stb,
  output logic [CW-1:0] bitCnt,
  output logic          running
);
  localparam int OUT_LAST = ABITS + IBITS - 1;

  logic syncQ;
  logic startPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= 1'b0;
      startPend <= 1'b0;
      running   <= 1'b0;
      bitCnt    <= '0;
    end else begin
      syncQ     <= syncIn;
      startPend <= syncQ & ~syncIn;
      if (startPend) begin
        bitCnt  <= '0;
        running <= 1'b1;
      end else if (running) begin
        bitCnt <= (bitCnt == CW'(WORD_BITS - 1)) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  logic inWin;
  always_comb begin
    inWin          = running && (bitCnt >= CW'(ABITS)) && (bitCnt <= CW'(OUT_LAST));
    stb.addrShift  = running && (bitCnt < CW'(ABITS - 1));
    stb.instrLoad  = running && (bitCnt == CW'(ABITS - 1));
    stb.instrShift = inWin;
    stb.outWin     = inWin;
    stb.snoopShift = inWin && (bitCnt != CW'(OUT_LAST));
    stb.decode     = running && (bitCnt == CW'(OUT_LAST));
  end
endmodule

// File: rtl/srom_datapath.sv
module srom_datapath import srom_pkg::*; #(
  parameter int BANK_ID = 0,
  parameter int ABITS   = 8,
  parameter int IBITS   = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    initIn,
  input  logic    addrIn,
  input  logic    instrBus,
  input  strobe_t stb,
  output logic    instrOut,
  output logic    enState
);
  localparam int DEPTH = 1 << ABITS;
  localparam logic RESET_EN = (BANK_ID == 0);

  function automatic logic [DEPTH*IBITS-1:0] buildImage();
    logic [DEPTH*IBITS-1:0] img;
    img = '0;
    for (int a = 0; a < DEPTH; a++) img[a*IBITS +: IBITS] = romWord(BANK_ID, a);
    return img;
  endfunction

  localparam logic [DEPTH*IBITS-1:0] IMAGE = buildImage();

  logic [ABITS-2:0] addrSr;
  logic [IBITS-1:0] instrSr;
  logic [IBITS-2:0] snoopSr;
  logic [ABITS-1:0] fetchAddr;
  logic [IBITS-1:0] fetchWord;
  logic [IBITS-1:0] snoopWord;
  logic             isSelect;
  logic             selMatch;

  always_comb begin
    fetchAddr = {addrIn, addrSr};
    fetchWord = IMAGE[int'(fetchAddr)*IBITS +: IBITS];
    snoopWord = {instrBus, snoopSr};
    isSelect  = (snoopWord & SEL_MASK) == SEL_CODE;
    selMatch  = snoopWord[IBITS-1:IBITS-3] == 3'(BANK_ID);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSr  <= '0;
      instrSr <= '0;
      snoopSr <= '0;
    end else begin
      if (stb.addrShift)  addrSr  <= {addrIn, addrSr[ABITS-2:1]};
      if (stb.instrLoad)  instrSr <= fetchWord;
      else if (stb.instrShift) instrSr <= {1'b0, instrSr[IBITS-1:1]};
      if (stb.snoopShift) snoopSr <= {instrBus, snoopSr[IBITS-2:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     enState <= RESET_EN;
    else if (initIn)               enState <= RESET_EN;
    else if (stb.decode && isSelect) enState <= selMatch;
  end

  assign instrOut = enState & stb.outWin & instrSr[0];
endmodule

// File: rtl/serial_rom_bank.sv
module serial_rom_bank import srom_pkg::*; #(
  parameter int BANK_ID   = 0,
  parameter int WORD_BITS = 56
) (
  input  logic clk,
  input  logic rstN,
  input  logic initIn,
  input  logic syncIn,
  input  logic addrIn,
  input  logic instrBus,
  output logic instrOut
);
  localparam int CW = $clog2(WORD_BITS);

  strobe_t       stb;
  logic [CW-1:0] bitCnt;
  logic          running;
  logic          enState;

  srom_ctrl #(.WORD_BITS(WORD_BITS), .ABITS(ADDR_BITS), .IBITS(INSTR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn),
    .stb(stb), .bitCnt(bitCnt), .running(running)
  );

  srom_datapath #(.BANK_ID(BANK_ID), .ABITS(ADDR_BITS), .IBITS(INSTR_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .initIn(initIn), .addrIn(addrIn),
    .instrBus(instrBus), .stb(stb), .instrOut(instrOut), .enState(enState)
  );
endmodule

// File: rtl/serial_rom_bank_checker.sv
module serial_rom_bank_checker #(
  parameter int BANK_ID   = 0,
  parameter int WORD_BITS = 56,
  parameter int ABITS     = 8,
  parameter int IBITS     = 10,
  localparam int CW       = $clog2(WORD_BITS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          initIn,
  input logic          syncIn,
  input logic          instrOut,
  input logic          enState,
  input logic [CW-1:0] bitCnt,
  input logic          running
);
  localparam int OUT_LAST = ABITS + IBITS - 1;

  p_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    !enState |-> !instrOut);

  p_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!running || bitCnt < CW'(ABITS) || bitCnt > CW'(OUT_LAST)) |-> !instrOut);

  p_word_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncIn) |=> ##1 (running && bitCnt == '0));

  p_init_r6: assert property (@(posedge clk) disable iff (!rstN)
    initIn |=> (enState == (BANK_ID == 0)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!initIn && !(running && bitCnt == CW'(OUT_LAST))) |=> $stable(enState));
endmodule

bind serial_rom_bank serial_rom_bank_checker #(.BANK_ID(BANK_ID), .WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .initIn(initIn), .syncIn(syncIn), .instrOut(instrOut),
  .enState(enState), .bitCnt(bitCnt), .running(running)
);

// File: tb/serial_rom_bank_bench.sv
`timescale 1ns/1ps
module serial_rom_bank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initIn = 1'b0;
  logic syncIn = 1'b0;
  logic addrIn = 1'b0;
  logic [2:0] outs;
  logic bus;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;
  assign bus = |outs;

  for (genvar b = 0; b < 3; b++) begin : g_bank
    serial_rom_bank #(.BANK_ID(b)) u_serial_rom_bank (
      .clk(clk), .rstN(rstN), .initIn(initIn), .syncIn(syncIn),
      .addrIn(addrIn), .instrBus(bus), .instrOut(outs[b])
    );
  end

  // Independent content model (R2).
  function automatic logic [9:0] refWord(input int bank, input logic [7:0] a);
    int v;
    if (a >= 8'hF0 && a <= 8'hF7) return {a[2:0], 7'b0010000};
    v = (a * 13 + bank * 101 + 5) % 1024;
    if ((v % 32) == 16) v = v + 1;
    return 10'(v);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [7:0] a, output logic [9:0] got, output bit quiet);
    quiet = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (bus) quiet = 1'b0;
      addrIn = a[k];
    end
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      got[j] = bus;
    end
    addrIn = 1'b0;
  endtask

  task automatic doWord(input logic [7:0] a, input int hiCycles,
                        output logic [9:0] got, output bit quiet);
    @(negedge clk);
    syncIn = 1'b1;
    repeat (hiCycles - 1) @(negedge clk);
    @(negedge clk);
    syncIn = 1'b0;
    @(negedge clk);
    sendWord(a, got, quiet);
  endtask

  typedef struct packed { logic [7:0] addr; logic [2:0] bank; } vec_t;
  localparam vec_t VECS [12] = '{
    '{8'h00, 3'd0}, '{8'h01, 3'd0}, '{8'h37, 3'd0}, '{8'hF1, 3'd0},
    '{8'h00, 3'd1}, '{8'h5A, 3'd1}, '{8'hF2, 3'd1},
    '{8'hFF, 3'd2}, '{8'h80, 3'd2}, '{8'hF0, 3'd2},
    '{8'h12, 3'd0}, '{8'hAB, 3'd0}
  };

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0] got;
    bit quiet;
    repeat (3) @(negedge clk);
    check(bus == 1'b0, "R4 reset output quiet", bus, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(bus == 1'b0, "R4 idle output quiet", bus, 0);

    // R1 R2 R5 R7: table of address and owning bank
    foreach (VECS[i]) begin
      doWord(VECS[i].addr, 1, got, quiet);
      check(got == refWord(VECS[i].bank, VECS[i].addr), "R1 R2 R7 table word", got,
            refWord(VECS[i].bank, VECS[i].addr));
      if (i < 3) check(quiet, "R4 quiet before window", 1, 0);
    end

    // R3: free-running wrap, no new sync; window starts 56 periods later
    repeat (38) @(negedge clk);
    sendWord(8'h33, got, quiet);
    check(got == refWord(0, 8'h33), "R3 wrap word", got, refWord(0, 8'h33));
    check(quiet, "R4 quiet on wrapped word", 0, 1);

    // R3: long sync pulse keeps the same offset
    doWord(8'h44, 4, got, quiet);
    check(got == refWord(0, 8'h44), "R3 long sync", got, refWord(0, 8'h44));

    // R5: select of a missing bank silences the line
    doWord(8'hF5, 1, got, quiet);
    check(got == refWord(0, 8'hF5), "R5 select word seen", got, refWord(0, 8'hF5));
    doWord(8'h21, 1, got, quiet);
    check(got == 10'd0, "R5 no bank enabled", got, 0);

    // R6: init restores bank 0
    @(negedge clk); initIn = 1'b1;
    @(negedge clk); initIn = 1'b0;
    doWord(8'h00, 1, got, quiet);
    check(got == refWord(0, 8'h00), "R6 init from silence", got, refWord(0, 8'h00));

    // R6: init after switching to bank 2 clears bank 2
    doWord(8'hF2, 1, got, quiet);
    doWord(8'h66, 1, got, quiet);
    check(got == refWord(2, 8'h66), "R5 switch to bank2", got, refWord(2, 8'h66));
    @(negedge clk); initIn = 1'b1;
    @(negedge clk); initIn = 1'b0;
    doWord(8'h66, 1, got, quiet);
    check(got == refWord(0, 8'h66), "R6 init after switch", got, refWord(0, 8'h66));

    // R6: reset mid-run also returns to bank 0
    doWord(8'hF1, 1, got, quiet);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    doWord(8'h9C, 1, got, quiet);
    check(got == refWord(0, 8'h9C), "R6 reset restores bank0", got, refWord(0, 8'h9C));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule